// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a global shared address into the number of the node that owns it and an address local to that node. It keeps a small, fully associative table of segment descriptors that software loads through a simple write port. Each descriptor covers a power-of-two sized region aligned to its own size. Each one names a power-of-two range of owning nodes, the position of the address bits that pick a node inside that range, and a cache attribute.

A lookup presents an address with a valid strobe. One clock later the block returns the owning node, the compacted local address, the cache attribute, and a fault flag when no descriptor covers the address. Translation uses segments only. There are no pages, no translation cache and no table walk. The write port refuses descriptors that would be malformed, and a refused write leaves the old entry in place.

Top module: `seg_xlate`

## Requirements
- R1: A write with `cfg_we` high stores the descriptor into entry `cfg_idx` at the next rising edge. The entry then covers every address whose bits above `cfg_len_log2` equal the same bits of `cfg_base`.
- R2: A write is refused and the entry keeps its previous contents when either of these holds: `cfg_base` has a set bit below bit `cfg_len_log2`, or `cfg_node_log2` is greater than NODE_W.
- R3: The cache attribute is coded 0 for non-cached, 1 for read-only cached and 2 for fully cached. A write carrying code 3 is refused. A lookup result never carries code 3.
- R4: For a hit, the node is `cfg_node_first` plus the `cfg_node_log2` offset bits starting at bit `cfg_ilv_pos`, taken modulo 2^NODE_W. With `cfg_node_log2` = 0 the node is `cfg_node_first`.
- R5: For a hit, the local address is the offset inside the segment with those node-select bits removed. Offset bits below `cfg_ilv_pos` stay where they are, and the bits above the removed field move down by `cfg_node_log2` places.
- R6: When no valid entry covers the address, the result has `res_fault` = 1, `res_node` = 0, `res_local` = 0 and `res_attr` = 0.
- R7: When several valid entries cover the address, the entry with the lowest index supplies the result.
- R8: `res_valid` is `lk_valid` delayed by one clock. The result outputs change only in the cycle after a lookup and otherwise hold their values.
- R9: Reset clears every entry, so every lookup after reset faults, and it clears all result outputs to 0.
- R10: A write with `cfg_en` = 0 invalidates the entry, so the entry no longer matches any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Entry written |
| cfg_en | input | 1 | Entry valid flag written |
| cfg_base | input | 32 | Segment base address |
| cfg_len_log2 | input | 5 | log2 of segment size |
| cfg_node_first | input | 6 | First node of the owning range |
| cfg_node_log2 | input | 3 | log2 of the number of owning nodes |
| cfg_ilv_pos | input | 5 | Lowest offset bit of the node-select field |
| cfg_attr | input | 2 | Cache attribute code |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Global address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_fault | output | 1 | No segment covered the address |
| res_node | output | 6 | Owning node |
| res_local | output | 32 | Local address at the owning node |
| res_attr | output | 2 | Cache attribute of the segment |

## Verification
The bench uses the defaults: 32-bit addresses, 6-bit node numbers and eight entries. The node field is therefore narrow enough that a first node near 63 plus a select value wraps past zero. Segment sizes range from 256 bytes to half the address space, so one descriptor can nest inside another at a higher or a lower index. With eight entries there are spare slots for the refused-write tests, which must show that the old contents of an entry survive a bad write.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ATTR_UNCACHED = 2'd0,
    ATTR_RDONLY   = 2'd1,
    ATTR_FULL     = 2'd2,
    ATTR_RSVD     = 2'd3
  } cache_attr_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int ADDR_W  = 32,
  parameter int NODE_W  = 6,
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int LEN_W  = $clog2(ADDR_W),
  localparam int NLOG_W = $clog2(NODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len_log2,
  input  logic [NODE_W-1:0] cfg_node_first,
  input  logic [NLOG_W-1:0] cfg_node_log2,
  input  logic [LEN_W-1:0]  cfg_ilv_pos,
  input  logic [1:0]        cfg_attr,
  output logic              ent_en    [NUM_SEG],
  output logic [ADDR_W-1:0] ent_base  [NUM_SEG],
  output logic [LEN_W-1:0]  ent_len   [NUM_SEG],
  output logic [NODE_W-1:0] ent_first [NUM_SEG],
  output logic [NLOG_W-1:0] ent_nlog  [NUM_SEG],
  output logic [LEN_W-1:0]  ent_pos   [NUM_SEG],
  output logic [1:0]        ent_attr  [NUM_SEG]
);
  import seg_xlate_pkg::*;

  logic [ADDR_W-1:0] low_mask;
  logic              aligned_ok;
  logic              nlog_ok;
  logic              attr_ok;
  logic              wr_ok;

  always_comb begin
    low_mask   = ~({ADDR_W{1'b1}} << cfg_len_log2);
    aligned_ok = (cfg_base & low_mask) == '0;
    nlog_ok    = 32'(cfg_node_log2) <= NODE_W;
    attr_ok    = cfg_attr != ATTR_RSVD;
    wr_ok      = cfg_we && aligned_ok && nlog_ok && attr_ok;
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
    logic ld;
    assign ld = wr_ok && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_en[i]    <= 1'b0;
        ent_base[i]  <= '0;
        ent_len[i]   <= '0;
        ent_first[i] <= '0;
        ent_nlog[i]  <= '0;
        ent_pos[i]   <= '0;
        ent_attr[i]  <= '0;
      end else if (ld) begin
        ent_en[i]    <= cfg_en;
        ent_base[i]  <= cfg_base;
        ent_len[i]   <= cfg_len_log2;
        ent_first[i] <= cfg_node_first;
        ent_nlog[i]  <= cfg_node_log2;
        ent_pos[i]   <= cfg_ilv_pos;
        ent_attr[i]  <= cfg_attr;
      end
    end
  end
endmodule

// File: rtl/seg_match.sv
module seg_match #(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int LEN_W  = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ent_en   [NUM_SEG],
  input  logic [ADDR_W-1:0] ent_base [NUM_SEG],
  input  logic [LEN_W-1:0]  ent_len  [NUM_SEG],
  output logic              any_hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [NUM_SEG-1:0] hit;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_cmp
    logic [ADDR_W-1:0] hi_mask;
    assign hi_mask = {ADDR_W{1'b1}} << ent_len[i];
    assign hit[i]  = ent_en[i] && ((addr & hi_mask) == ent_base[i]);
  end

  // Scan from the top so the lowest matching index is the last one kept.
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_SEG - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
    any_hit = |hit;
  end
endmodule

// File: rtl/seg_calc.sv
module seg_calc #(
  parameter int ADDR_W  = 32,
  parameter int NODE_W  = 6,
  localparam int LEN_W  = $clog2(ADDR_W),
  localparam int NLOG_W = $clog2(NODE_W + 1),
  localparam int SH_W   = LEN_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [NODE_W-1:0] first,
  input  logic [NLOG_W-1:0] nlog,
  input  logic [LEN_W-1:0]  pos,
  output logic [NODE_W-1:0] node,
  output logic [ADDR_W-1:0] local_addr
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] sel_full;
  logic [ADDR_W-1:0] keep_low;
  logic [ADDR_W-1:0] move_high;
  logic [SH_W-1:0]   skip;

  always_comb begin
    off       = addr & ~({ADDR_W{1'b1}} << len);
    sel_full  = (off >> pos) & ~({ADDR_W{1'b1}} << nlog);
    skip      = SH_W'(pos) + SH_W'(nlog);
    keep_low  = off & ~({ADDR_W{1'b1}} << pos);
    move_high = (off >> skip) << pos;
    node       = first + sel_full[NODE_W-1:0];
    local_addr = move_high | keep_low;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W  = 32,
  parameter int NODE_W  = 6,
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int LEN_W  = $clog2(ADDR_W),
  localparam int NLOG_W = $clog2(NODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len_log2,
  input  logic [NODE_W-1:0] cfg_node_first,
  input  logic [NLOG_W-1:0] cfg_node_log2,
  input  logic [LEN_W-1:0]  cfg_ilv_pos,
  input  logic [1:0]        cfg_attr,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_fault,
  output logic [NODE_W-1:0] res_node,
  output logic [ADDR_W-1:0] res_local,
  output logic [1:0]        res_attr
);
  logic              ent_en    [NUM_SEG];
  logic [ADDR_W-1:0] ent_base  [NUM_SEG];
  logic [LEN_W-1:0]  ent_len   [NUM_SEG];
  logic [NODE_W-1:0] ent_first [NUM_SEG];
  logic [NLOG_W-1:0] ent_nlog  [NUM_SEG];
  logic [LEN_W-1:0]  ent_pos   [NUM_SEG];
  logic [1:0]        ent_attr  [NUM_SEG];

  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [NODE_W-1:0] calc_node;
  logic [ADDR_W-1:0] calc_local;

  logic              nxt_fault;
  logic [NODE_W-1:0] nxt_node;
  logic [ADDR_W-1:0] nxt_local;
  logic [1:0]        nxt_attr;

  seg_table #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .NUM_SEG(NUM_SEG)) u_table (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_en, .cfg_base, .cfg_len_log2,
    .cfg_node_first, .cfg_node_log2, .cfg_ilv_pos, .cfg_attr,
    .ent_en, .ent_base, .ent_len, .ent_first, .ent_nlog, .ent_pos, .ent_attr
  );

  seg_match #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) u_match (
    .addr(lk_addr), .ent_en, .ent_base, .ent_len, .any_hit, .hit_idx
  );

  seg_calc #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) u_calc (
    .addr(lk_addr), .len(ent_len[hit_idx]), .first(ent_first[hit_idx]),
    .nlog(ent_nlog[hit_idx]), .pos(ent_pos[hit_idx]),
    .node(calc_node), .local_addr(calc_local)
  );

  always_comb begin
    nxt_fault = !any_hit;
    nxt_node  = any_hit ? calc_node          : '0;
    nxt_local = any_hit ? calc_local         : '0;
    nxt_attr  = any_hit ? ent_attr[hit_idx]  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fault <= 1'b0;
      res_node  <= '0;
      res_local <= '0;
      res_attr  <= '0;
    end else if (lk_valid) begin
      res_fault <= nxt_fault;
      res_node  <= nxt_node;
      res_local <= nxt_local;
      res_attr  <= nxt_attr;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int NODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              res_valid,
  input logic              res_fault,
  input logic [NODE_W-1:0] res_node,
  input logic [ADDR_W-1:0] res_local,
  input logic [1:0]        res_attr
);
  // R8: a result appears exactly one cycle after each request
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  // R8: without a request the result fields hold
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(res_node) && $stable(res_local) &&
                   $stable(res_attr) && $stable(res_fault)));
  // R6: a fault reports zeros
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_node == '0 && res_local == '0 && res_attr == 2'd0));
  // R3: reserved attribute code never leaves the block
  a_r3_attr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_attr != 2'd3));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
  .res_fault(res_fault), .res_node(res_node), .res_local(res_local),
  .res_attr(res_attr)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic        cfg_en;
  logic [31:0] cfg_base;
  logic [4:0]  cfg_len_log2;
  logic [5:0]  cfg_node_first;
  logic [2:0]  cfg_node_log2;
  logic [4:0]  cfg_ilv_pos;
  logic [1:0]  cfg_attr;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        res_valid;
  logic        res_fault;
  logic [5:0]  res_node;
  logic [31:0] res_local;
  logic [1:0]  res_attr;

  int checks = 0;
  int errors = 0;

  seg_xlate dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Rows: address, fault, node, local, attr
  localparam int NV = 9;
  localparam logic [31:0] V_ADDR  [NV] = '{32'h0000_1234, 32'h0000_FFF0, 32'h1001_2345,
    32'h10AB_CDEF, 32'h8000_0003, 32'h8000_0101, 32'h2000_0000, 32'h0000_0010, 32'h0000_0000};
  localparam logic        V_FAULT [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam logic [5:0]  V_NODE  [NV] = '{6'd7, 6'd7, 6'd10, 6'd34, 6'd1, 6'd63, 6'd0, 6'd5, 6'd4};
  localparam logic [31:0] V_LOCAL [NV] = '{32'h484, 32'h3FF0, 32'h12345, 32'h1BCDEF,
    32'h0, 32'h40, 32'h0, 32'h0, 32'h0};
  localparam logic [1:0]  V_ATTR  [NV] = '{2'd1, 2'd1, 2'd2, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic en, input logic [31:0] base,
                    input logic [4:0] len, input logic [5:0] first, input logic [2:0] nlog,
                    input logic [4:0] pos, input logic [1:0] attr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_base = base; cfg_len_log2 = len;
    cfg_node_first = first; cfg_node_log2 = nlog; cfg_ilv_pos = pos; cfg_attr = attr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic f, input logic [5:0] n,
                            input logic [31:0] l, input logic [1:0] at);
    check({tag, " valid"}, 64'(res_valid), 64'(1'b1));
    check({tag, " fault"}, 64'(res_fault), 64'(f));
    check({tag, " node"},  64'(res_node),  64'(n));
    check({tag, " local"}, 64'(res_local), 64'(l));
    check({tag, " attr"},  64'(res_attr),  64'(at));
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_en = 1'b0; cfg_base = '0;
    cfg_len_log2 = '0; cfg_node_first = '0; cfg_node_log2 = '0; cfg_ilv_pos = '0;
    cfg_attr = '0; lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset res_valid", 64'(res_valid), 64'(0));
    check("R9 reset res_node",  64'(res_node),  64'(0));
    rst_n = 1'b1;

    // R1: load descriptors
    wr(3'd0, 1'b1, 32'h0000_0000, 5'd16, 6'd4,  3'd2, 5'd4,  2'd1);
    wr(3'd1, 1'b1, 32'h1000_0000, 5'd20, 6'd10, 3'd0, 5'd0,  2'd2);
    wr(3'd2, 1'b1, 32'h1000_0000, 5'd24, 6'd32, 3'd3, 5'd20, 2'd0);
    wr(3'd3, 1'b1, 32'h8000_0000, 5'd31, 6'd62, 3'd2, 5'd0,  2'd1);
    wr(3'd5, 1'b1, 32'h0000_0000, 5'd8,  6'd1,  3'd0, 5'd0,  2'd2);

    // Vector table: R1 R4 R5 (mapping), R4 wrap, R6 miss, R7 overlap priority
    for (int i = 0; i < NV; i++) begin
      look(V_ADDR[i]);
      expect_res($sformatf("R1/R4/R5/R6/R7 row %0d", i), V_FAULT[i], V_NODE[i], V_LOCAL[i], V_ATTR[i]);
    end

    // R8: no request -> valid drops, fields hold
    @(negedge clk);
    check("R8 idle res_valid", 64'(res_valid), 64'(0));
    check("R8 idle hold node", 64'(res_node), 64'(4));
    lk_addr = 32'h2000_0000;
    @(negedge clk);
    check("R8 idle hold fault", 64'(res_fault), 64'(0));

    // R2: misaligned base is refused
    wr(3'd6, 1'b1, 32'h3000_0100, 5'd12, 6'd9, 3'd0, 5'd0, 2'd2);
    look(32'h3000_0100);
    expect_res("R2 misaligned refused", 1'b1, 6'd0, 32'h0, 2'd0);
    wr(3'd6, 1'b1, 32'h3000_0000, 5'd12, 6'd9, 3'd0, 5'd0, 2'd2);
    look(32'h3000_0100);
    expect_res("R1 aligned accepted", 1'b0, 6'd9, 32'h100, 2'd2);
    // R3: attribute code 3 refused, old entry kept
    wr(3'd6, 1'b1, 32'h4000_0000, 5'd12, 6'd3, 3'd0, 5'd0, 2'd3);
    look(32'h4000_0000);
    expect_res("R3 reserved attr refused", 1'b1, 6'd0, 32'h0, 2'd0);
    look(32'h3000_0004);
    expect_res("R3 old entry kept", 1'b0, 6'd9, 32'h4, 2'd2);
    // R2: oversized node count refused
    wr(3'd6, 1'b1, 32'h4000_0000, 5'd12, 6'd3, 3'd7, 5'd0, 2'd1);
    look(32'h4000_0000);
    expect_res("R2 node_log2 refused", 1'b1, 6'd0, 32'h0, 2'd0);

    // R10: invalidate entry 1, address falls through to entry 2
    wr(3'd1, 1'b0, 32'h1000_0000, 5'd20, 6'd10, 3'd0, 5'd0, 2'd2);
    look(32'h1001_2345);
    expect_res("R10 invalidated", 1'b0, 6'd32, 32'h12345, 2'd0);

    // R9: reset clears table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(32'h0000_1234);
    expect_res("R9 table cleared", 1'b1, 6'd0, 32'h0, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule